// File: doc/BRIEF.md
# Eight-State Cyclic Sequencer with Selectable Encoding

This block is a state register that walks through eight states in a ring, from state 0 to state 7 and back to state 0. It advances one state on each clock edge while the step input is high. A parameter picks how the state is stored in flops: plain binary, reflected Gray, a four-bit twisted-ring (Johnson) code, or one-hot. The choice trades flop count against how many bits toggle on each step and how many stored patterns can be told apart from legal states.

The block presents the raw stored code and a decoded three-bit state index. It also raises an error flag whenever the stored pattern is not one of the eight codes that belong to the selected encoding. On the next clock edge after such a pattern is seen, the register returns to the code for state 0. A test-only load input forces any raw pattern into the register, so that detection and recovery can be exercised. Surrounding logic uses the index as a phase count and the flag as a corruption indicator.

Top module: `octo_seq`

## Requirements
- R1: An active-low asynchronous reset puts the register at the state-0 code: 000 for binary and Gray, 0000 for Johnson, 00000001 for one-hot.
- R2: With binary encoding, the code for state n is n written in three bits.
- R3: With Gray encoding, the codes for states 0 through 7 are 000, 001, 011, 010, 110, 111, 101, 100. Consecutive states differ in exactly one bit.
- R4: With Johnson encoding, the codes for states 0 through 7 are 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000. Consecutive states differ in exactly one bit.
- R5: With one-hot encoding, the code for state n has only bit n set.
- R6: While the stored code is legal, and both step and load are low, the code does not change across a clock edge.
- R7: A step from state 7 moves to state 0.
- R8: illegal_o is high in the same cycle in which the stored code is not one of the eight legal codes of the encoding. With binary and Gray it never goes high.
- R9: On the clock edge after an illegal code is held, and with load low, the register takes the state-0 code whatever the value of step.
- R10: idx_o gives the state number of a legal stored code. It is 0 while the code is illegal. A step from state n (n < 7) makes idx_o equal n+1.
- R11: When force_i is high at a clock edge, the register takes force_code_i as given. This takes priority over recovery and over stepping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance to the next state at this edge |
| force_i | input | 1 | Test hook: load force_code_i at this edge |
| force_code_i | input | CW (3, 3, 4 or 8) | Raw pattern for the test load |
| code_o | output | CW (3, 3, 4 or 8) | Stored state code |
| idx_o | output | 3 | Decoded state number |
| illegal_o | output | 1 | Stored code is not legal for the encoding |

## Verification
The bench builds four copies of the block side by side, one for each value of the encoding parameter, and drives all four with the same step, load and reset stimulus. Only the Johnson and one-hot builds have unused patterns, so only those two can show detection and recovery. The binary and Gray builds are loaded with the same forced data and confirm that every pattern decodes as legal. Running all four together also checks that every build wraps and holds in the same cycles, whatever the encoding.

// File: rtl/oseq_pkg.sv
package oseq_pkg;

  typedef enum logic [1:0] {
    ENC_BIN     = 2'd0,
    ENC_GRAY    = 2'd1,
    ENC_JOHNSON = 2'd2,
    ENC_ONEHOT  = 2'd3
  } enc_e;

  localparam int unsigned NSTATE = 8;
  localparam int unsigned IDXW   = $clog2(NSTATE);
  localparam int unsigned JW     = NSTATE / 2;
  localparam int unsigned MAXW   = NSTATE;

  // Flop count needed by each encoding.
  function automatic int unsigned code_width(enc_e e);
    case (e)
      ENC_BIN, ENC_GRAY: return IDXW;
      ENC_JOHNSON:       return JW;
      default:           return NSTATE;
    endcase
  endfunction

  // Codes with no unused patterns need no legality test.
  function automatic bit is_dense(enc_e e);
    return (e == ENC_BIN) || (e == ENC_GRAY);
  endfunction

  // State number -> code, zero-extended to MAXW bits.
  function automatic logic [MAXW-1:0] encode(enc_e e, logic [IDXW-1:0] i);
    logic [MAXW-1:0] r;
    int iv;
    r  = '0;
    iv = int'(i);
    case (e)
      ENC_BIN:  r = MAXW'(i);
      ENC_GRAY: r = MAXW'(i ^ (i >> 1));
      ENC_JOHNSON: begin
        for (int j = 0; j < int'(JW); j++) begin
          r[j] = (iv > j) && (iv <= j + int'(JW));
        end
      end
      default: r[i] = 1'b1;
    endcase
    return r;
  endfunction

  // Code -> state number. Illegal codes give some number whose
  // re-encoding differs from the code.
  function automatic logic [IDXW-1:0] decode(enc_e e, logic [MAXW-1:0] c);
    logic [IDXW-1:0] r;
    int unsigned ones;
    r    = '0;
    ones = 0;
    case (e)
      ENC_BIN: r = c[IDXW-1:0];
      ENC_GRAY: begin
        r[IDXW-1] = c[IDXW-1];
        for (int b = int'(IDXW) - 2; b >= 0; b--) begin
          r[b] = r[b+1] ^ c[b];
        end
      end
      ENC_JOHNSON: begin
        for (int b = 0; b < int'(JW); b++) begin
          if (c[b]) ones++;
        end
        r = c[JW-1] ? IDXW'(NSTATE - ones) : IDXW'(ones);
      end
      default: begin
        for (int b = int'(MAXW) - 1; b >= 0; b--) begin
          if (c[b]) r = IDXW'(b);
        end
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/oseq_decode.sv
module oseq_decode
  import oseq_pkg::*;
#(
  parameter enc_e ENC = ENC_GRAY,
  localparam int unsigned CW = code_width(ENC)
) (
  input  logic [CW-1:0]   code_i,
  output logic [IDXW-1:0] idx_o,
  output logic            legal_o
);

  logic [MAXW-1:0] code_ext;
  assign code_ext = MAXW'(code_i);
  assign idx_o    = decode(ENC, code_ext);

  if (is_dense(ENC)) begin : g_dense
    assign legal_o = 1'b1;
  end else begin : g_sparse
    logic [CW-1:0] back_code;
    assign back_code = CW'(encode(ENC, idx_o));
    assign legal_o   = (back_code == code_i);
  end

endmodule

// File: rtl/oseq_advance.sv
module oseq_advance
  import oseq_pkg::*;
#(
  parameter enc_e ENC = ENC_GRAY,
  localparam int unsigned CW = code_width(ENC)
) (
  input  logic [IDXW-1:0] idx_i,
  output logic [CW-1:0]   next_code_o,
  output logic            wrap_o
);

  logic [IDXW-1:0] idx_nxt;

  assign wrap_o      = (idx_i == IDXW'(NSTATE - 1));
  assign idx_nxt     = wrap_o ? '0 : idx_i + 1'b1;
  assign next_code_o = CW'(encode(ENC, idx_nxt));

endmodule

// File: rtl/oseq_state_reg.sv
module oseq_state_reg #(
  parameter int unsigned CW = 3,
  parameter logic [CW-1:0] RST_CODE = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_code_i,
  input  logic          recover_i,
  input  logic          adv_i,
  input  logic [CW-1:0] adv_code_i,
  output logic [CW-1:0] q_o
);

  logic [CW-1:0] d;

  always_comb begin
    d = q_o;
    if (load_i)         d = load_code_i;
    else if (recover_i) d = RST_CODE;
    else if (adv_i)     d = adv_code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_CODE;
    else         q_o <= d;
  end

endmodule

// File: rtl/octo_seq.sv
module octo_seq
  import oseq_pkg::*;
#(
  parameter enc_e ENC = ENC_GRAY,
  localparam int unsigned CW = code_width(ENC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            force_i,
  input  logic [CW-1:0]   force_code_i,
  output logic [CW-1:0]   code_o,
  output logic [IDXW-1:0] idx_o,
  output logic            illegal_o
);

  localparam logic [CW-1:0] ZERO_CODE = CW'(encode(ENC, '0));

  logic [CW-1:0]   cur_code;
  logic [CW-1:0]   inc_code;
  logic [IDXW-1:0] cur_idx;
  logic            cur_legal;
  logic            wrap_w;
  logic            recover_w;
  logic            adv_w;

  oseq_decode #(.ENC(ENC)) u_decode (
    .code_i (cur_code),
    .idx_o  (cur_idx),
    .legal_o(cur_legal)
  );

  oseq_advance #(.ENC(ENC)) u_advance (
    .idx_i      (cur_idx),
    .next_code_o(inc_code),
    .wrap_o     (wrap_w)
  );

  assign recover_w = !cur_legal && !force_i;
  assign adv_w     = cur_legal && step_i && !force_i;

  oseq_state_reg #(.CW(CW), .RST_CODE(ZERO_CODE)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (force_i),
    .load_code_i(force_code_i),
    .recover_i  (recover_w),
    .adv_i      (adv_w),
    .adv_code_i (inc_code),
    .q_o        (cur_code)
  );

  assign code_o    = cur_code;
  assign idx_o     = cur_legal ? cur_idx : '0;
  assign illegal_o = !cur_legal;

endmodule

// File: rtl/octo_seq_chk.sv
module octo_seq_chk
  import oseq_pkg::*;
#(
  parameter enc_e ENC = ENC_GRAY,
  localparam int unsigned CW = code_width(ENC)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            step_i,
  input logic            force_i,
  input logic [CW-1:0]   force_code_i,
  input logic [CW-1:0]   code_o,
  input logic [IDXW-1:0] idx_o,
  input logic            illegal_o,
  input logic            adv_w,
  input logic            wrap_w
);

  localparam logic [CW-1:0] ZERO_CODE = CW'(encode(ENC, '0));

  AST_FORCE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (code_o == $past(force_code_i))); // R11

  AST_RECOVER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_o && !force_i) |=> (code_o == ZERO_CODE)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && !step_i && !force_i) |=> $stable(code_o)); // R6

  AST_STEP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && wrap_w) |=> (idx_o == '0 && !illegal_o)); // R7

  AST_STEP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_w && !wrap_w) |=> (idx_o == IDXW'($past(idx_o) + 1'b1))); // R10

  AST_ILLEGAL_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (idx_o == '0)); // R10

  AST_DENSE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !is_dense(ENC)); // R8

  AST_ONEHOT_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!illegal_o && ENC == ENC_ONEHOT) |-> ($countones(code_o) == 1)); // R5

endmodule

bind octo_seq octo_seq_chk #(.ENC(ENC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .force_i     (force_i),
  .force_code_i(force_code_i),
  .code_o      (code_o),
  .idx_o       (idx_o),
  .illegal_o   (illegal_o),
  .adv_w       (adv_w),
  .wrap_w      (wrap_w)
);

// File: tb/octo_seq_tb.sv
module octo_seq_tb;
  import oseq_pkg::*;

  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic frc = 1'b0;
  logic [7:0] fcode [4];
  logic [7:0] code_w [4];
  logic [2:0] idx_w [4];
  logic       ill_w [4];

  int vectors = 0;
  int fails = 0;
  int mcode [4];
  string code_tag [4] = '{"R2", "R3", "R4", "R5"};
  int gray_tab [8] = '{0, 1, 3, 2, 6, 7, 5, 4};
  int john_tab [8] = '{0, 1, 3, 7, 15, 14, 12, 8};
  int mask_tab [4] = '{7, 7, 15, 255};

  always #(CLK_PERIOD / 2) clk = ~clk;

  for (genvar k = 0; k < 4; k++) begin : g_enc
    localparam enc_e E = enc_e'(k);
    localparam int unsigned W = code_width(E);
    logic [W-1:0] c;
    octo_seq #(.ENC(E)) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .step_i      (step),
      .force_i     (frc),
      .force_code_i(fcode[k][W-1:0]),
      .code_o      (c),
      .idx_o       (idx_w[k]),
      .illegal_o   (ill_w[k])
    );
    assign code_w[k] = 8'(c);
  end

  function automatic int ref_code(int k, int i);
    case (k)
      0: return i;
      1: return gray_tab[i];
      2: return john_tab[i];
      default: return 1 << i;
    endcase
  endfunction

  // -1 when the code is not one of the eight legal ones
  function automatic int ref_idx(int k, int c);
    for (int i = 0; i < 8; i++) if (ref_code(k, i) == c) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 4; k++) begin
      int ix;
      ix = ref_idx(k, mcode[k]);
      if (!rst_n)       mcode[k] = ref_code(k, 0);
      else if (frc)     mcode[k] = int'(fcode[k]) & mask_tab[k];
      else if (ix < 0)  mcode[k] = ref_code(k, 0);
      else if (step)    mcode[k] = ref_code(k, (ix + 1) % 8);
    end
  end

  task automatic chk(string tag, int k, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s enc%0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < 4; k++) begin
      int ix;
      ix = ref_idx(k, mcode[k]);
      chk(code_tag[k], k, int'(code_w[k]), mcode[k]);
      chk("R10", k, int'(idx_w[k]), (ix < 0) ? 0 : ix);
      chk("R8", k, int'(ill_w[k]), (ix < 0) ? 1 : 0);
    end
  endtask

  task automatic cyc(bit s, bit f);
    step = s;
    frc = f;
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int saved [4];
    for (int k = 0; k < 4; k++) fcode[k] = '0;
    repeat (2) @(negedge clk);
    // R1 reset codes
    chk("R1", 0, int'(code_w[0]), 0);
    chk("R1", 1, int'(code_w[1]), 0);
    chk("R1", 2, int'(code_w[2]), 0);
    chk("R1", 3, int'(code_w[3]), 1);
    rst_n = 1'b1;
    // full ring: R7 wrap after eight steps
    for (int n = 0; n < 7; n++) cyc(1, 0);
    for (int k = 0; k < 4; k++) chk("R7", k, int'(idx_w[k]), 7);
    cyc(1, 0);
    for (int k = 0; k < 4; k++) chk("R7", k, int'(idx_w[k]), 0);
    cyc(1, 0);
    cyc(1, 0);
    // R6 hold
    for (int k = 0; k < 4; k++) saved[k] = int'(code_w[k]);
    repeat (3) cyc(0, 0);
    for (int k = 0; k < 4; k++) chk("R6", k, int'(code_w[k]), saved[k]);
    // R8/R9 forced patterns, recovery with step low
    fcode[0] = 8'd5; fcode[1] = 8'd6; fcode[2] = 8'b0101; fcode[3] = 8'b0000_0110;
    cyc(0, 1);
    chk("R8", 0, int'(ill_w[0]), 0);
    chk("R8", 1, int'(ill_w[1]), 0);
    chk("R8", 2, int'(ill_w[2]), 1);
    chk("R8", 3, int'(ill_w[3]), 1);
    cyc(0, 0);
    chk("R9", 2, int'(code_w[2]), 0);
    chk("R9", 3, int'(code_w[3]), 1);
    chk("R9", 0, int'(code_w[0]), 5);
    // R11 load beats step; all-zero one-hot recovers with step high
    fcode[0] = 8'd2; fcode[1] = 8'd2; fcode[2] = 8'b1000; fcode[3] = 8'h00;
    cyc(1, 1);
    chk("R11", 0, int'(code_w[0]), 2);
    chk("R11", 2, int'(code_w[2]), 8);
    chk("R11", 3, int'(code_w[3]), 0);
    cyc(1, 0);
    chk("R9", 3, int'(code_w[3]), 1);
    chk("R7", 2, int'(idx_w[2]), 0);
    // random traffic with an async reset pulse in the middle
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < 4; k++) fcode[k] = 8'($urandom);
      if (n == 200) begin
        rst_n = 1'b0;
        #1;
        compare_all();
        @(negedge clk);
        rst_n = 1'b1;
      end
      cyc(1'($urandom), ($urandom % 6) == 0);
    end
    summary();
    $finish;
  end

endmodule